// File: doc/BRIEF.md
# Multisample Run-Length Threshold Filter

The block sits in a readout data path and thins a stream of multisamples. Every incoming word carries six 16-bit samples taken from one channel of one front-end chip, together with that chip's number and the channel number. For each word the block fetches a threshold that belongs to exactly that chip and channel from an internal table. It keeps the word only if enough neighbouring samples rise above the threshold. Words that fail are removed from the stream completely. Surviving words leave in their original order and are not modified.

Configuration writes reach the threshold table through a dedicated write port, so table updates never compete with lookups. Two global settings shape the decision: the required run length and a filter enable. Clearing the enable, or setting the run length to zero, lets every word through, which is the setting used for calibration. The input stream is grouped into frames by start and end markers. The block moves these markers onto the words that survive, so a thinned frame stays well formed.

Top module: `msample_thresh_filter`

## Requirements
- R1: While reset is asserted, and after reset until a word is presented, out_valid stays low.
- R2: The threshold for a word is the table entry written for its own chip number and channel number (entry index chip*128+channel). Entries of other channels or other chips have no influence on it.
- R3: A sample counts as above threshold only when it is strictly greater than the threshold, compared as unsigned 16-bit values. A sample equal to the threshold does not count.
- R4: With the filter enabled and run length N in 1..6, a word passes when at least N samples at adjacent positions are above threshold. Sample k occupies in_data bits [16k+15:16k], and adjacency means consecutive k. Samples above threshold that are separated by a sample not above threshold do not form one run.
- R5: A word that fails the test produces no output word at all.
- R6: With cfg_filter_en low, or with cfg_min_run equal to 0, every word passes regardless of the thresholds.
- R7: With the filter enabled and cfg_min_run equal to 7, no word passes.
- R8: Surviving words leave in input order, with data, chip and channel unchanged.
- R9: Among the words that survive from one frame, the first carries out_sof and the last carries out_eof, even when the input words that carried those markers were dropped. A frame with no survivors produces no output. A frame's last survivor is released within three cycles after the frame's final input word.
- R10: A threshold write governs a word that is presented in the cycle right after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_thr_we | input | 1 | Threshold table write strobe |
| cfg_thr_chip | input | 5 | Chip number of the entry to write |
| cfg_thr_chan | input | 7 | Channel number of the entry to write |
| cfg_thr_value | input | 16 | Threshold value to write |
| cfg_min_run | input | 3 | Required run length N (0 = pass all) |
| cfg_filter_en | input | 1 | Filter enable (0 = pass all) |
| in_valid | input | 1 | Input word present |
| in_sof | input | 1 | Input word starts a frame |
| in_eof | input | 1 | Input word ends a frame |
| in_chip | input | 5 | Source chip number of the input word |
| in_chan | input | 7 | Channel number of the input word |
| in_data | input | 96 | Six 16-bit samples, sample k at bits [16k+15:16k] |
| out_valid | output | 1 | Output word present |
| out_sof | output | 1 | Output word is the first survivor of its frame |
| out_eof | output | 1 | Output word is the last survivor of its frame |
| out_chip | output | 5 | Source chip number of the output word |
| out_chan | output | 7 | Channel number of the output word |
| out_data | output | 96 | Samples of the output word |

## Verification
The hardest situation to reach is a frame whose marker-carrying words are both dropped while interior words survive. In the same situation a fully dropped frame sits between two frames and a passing end-of-frame word must be flushed while the next frame is already arriving. The stimulus reaches it by writing one threshold across a range of channels. It then streams three back-to-back frames whose words alternate between samples well below and well above that threshold, so that which words survive, and where the markers must move, is fixed by the sample values alone. The run-length rules are reached separately through single-word frames whose sample patterns put runs at the ends of the word, split runs by one low sample, and place values at the threshold itself.

// File: rtl/msf_pkg.sv
package msf_pkg;

  // Widest sample mask the run-length helper accepts.
  localparam int MASK_MAX = 32;

  // Length of the longest stretch of set bits in a mask.
  function automatic int unsigned longest_run(input logic [MASK_MAX-1:0] mask);
    int unsigned best;
    int unsigned cur;
    best = 0;
    cur  = 0;
    for (int i = 0; i < MASK_MAX; i++) begin
      if (mask[i]) begin
        cur = cur + 1;
        if (cur > best) best = cur;
      end else begin
        cur = 0;
      end
    end
    return best;
  endfunction

  // Linear table index of a {chip, channel} pair.
  function automatic int unsigned thr_index(input int unsigned chip,
                                            input int unsigned chan,
                                            input int unsigned chans);
    return chip * chans + chan;
  endfunction

endpackage

// File: rtl/msf_thresh_ram.sv
module msf_thresh_ram #(
  parameter int DEPTH = 2560,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  // Configuration port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Lookup port, one cycle of latency.
  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/msf_run_judge.sv
module msf_run_judge #(
  parameter int NSAMP  = 6,
  parameter int SAMP_W = 16,
  localparam int MS_W  = NSAMP * SAMP_W,
  localparam int RUN_W = $clog2(NSAMP + 1)
) (
  input  logic [MS_W-1:0]   data,
  input  logic [SAMP_W-1:0] thr,
  input  logic [RUN_W-1:0]  min_run,
  input  logic              filter_en,
  output logic [NSAMP-1:0]  above,
  output logic              pass
);
  import msf_pkg::*;

  logic [RUN_W-1:0] run_len;

  // One unsigned strict comparator per sample slot.
  for (genvar k = 0; k < NSAMP; k++) begin : g_cmp
    assign above[k] = data[k*SAMP_W +: SAMP_W] > thr;
  end

  assign run_len = RUN_W'(longest_run(MASK_MAX'(above)));

  always_comb begin
    if (!filter_en || (min_run == '0)) pass = 1'b1;
    else                               pass = (run_len >= min_run);
  end

endmodule

// File: rtl/msf_frame_keeper.sv
module msf_frame_keeper #(
  parameter int CHIP_W = 5,
  parameter int CHAN_W = 7,
  parameter int MS_W   = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_valid,
  input  logic              d_pass,
  input  logic              d_sof,
  input  logic              d_eof,
  input  logic [CHIP_W-1:0] d_chip,
  input  logic [CHAN_W-1:0] d_chan,
  input  logic [MS_W-1:0]   d_data,
  output logic              held_valid,
  output logic              held_eof,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [CHIP_W-1:0] out_chip,
  output logic [CHAN_W-1:0] out_chan,
  output logic [MS_W-1:0]   out_data
);

  logic              held_sof;
  logic [CHIP_W-1:0] held_chip;
  logic [CHAN_W-1:0] held_chan;
  logic [MS_W-1:0]   held_data;
  logic              first_pend;

  logic take;       // decided word survives and becomes the held word
  logic emit;       // held word leaves this cycle
  logic first_eff;  // next survivor opens a frame

  always_comb begin
    take      = d_valid && d_pass;
    emit      = held_valid && (held_eof || (d_valid && (d_pass || d_eof)));
    first_eff = first_pend || d_sof;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      first_pend <= 1'b1;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= emit;
      if (take)      held_valid <= 1'b1;
      else if (emit) held_valid <= 1'b0;
      if (d_valid) begin
        if (d_eof)       first_pend <= 1'b1;
        else if (d_pass) first_pend <= 1'b0;
        else             first_pend <= first_eff;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (emit) begin
      out_sof  <= held_sof;
      out_eof  <= held_eof || (d_valid && d_eof && !d_pass);
      out_chip <= held_chip;
      out_chan <= held_chan;
      out_data <= held_data;
    end
    if (take) begin
      held_sof  <= first_eff;
      held_eof  <= d_eof;
      held_chip <= d_chip;
      held_chan <= d_chan;
      held_data <= d_data;
    end
  end

endmodule

// File: rtl/msample_thresh_filter.sv
module msample_thresh_filter #(
  parameter int NUM_CHIPS = 20,
  parameter int CHANS     = 128,
  parameter int NSAMP     = 6,
  parameter int SAMP_W    = 16,
  localparam int CHIP_W   = $clog2(NUM_CHIPS),
  localparam int CHAN_W   = $clog2(CHANS),
  localparam int MS_W     = NSAMP * SAMP_W,
  localparam int RUN_W    = $clog2(NSAMP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_thr_we,
  input  logic [CHIP_W-1:0] cfg_thr_chip,
  input  logic [CHAN_W-1:0] cfg_thr_chan,
  input  logic [SAMP_W-1:0] cfg_thr_value,
  input  logic [RUN_W-1:0]  cfg_min_run,
  input  logic              cfg_filter_en,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [CHIP_W-1:0] in_chip,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [MS_W-1:0]   in_data,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [CHIP_W-1:0] out_chip,
  output logic [CHAN_W-1:0] out_chan,
  output logic [MS_W-1:0]   out_data
);
  import msf_pkg::*;

  localparam int DEPTH = NUM_CHIPS * CHANS;
  localparam int AW    = $clog2(DEPTH);

  // Table write side.
  logic          wr_ok;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic [SAMP_W-1:0] thr_q;

  assign wr_ok   = cfg_thr_we &&
                   ({1'b0, cfg_thr_chip} < (CHIP_W + 1)'(NUM_CHIPS));
  assign wr_addr = AW'(thr_index(cfg_thr_chip, cfg_thr_chan, CHANS));
  assign rd_addr = AW'(thr_index(in_chip, in_chan, CHANS));

  msf_thresh_ram #(.DEPTH(DEPTH), .DW(SAMP_W)) u_ram (
    .clk     (clk),
    .wr_en   (wr_ok),
    .wr_addr (wr_addr),
    .wr_data (cfg_thr_value),
    .rd_addr (rd_addr),
    .rd_data (thr_q)
  );

  // Data path delayed to line up with the table read.
  logic              s1_valid;
  logic              s1_sof;
  logic              s1_eof;
  logic [CHIP_W-1:0] s1_chip;
  logic [CHAN_W-1:0] s1_chan;
  logic [MS_W-1:0]   s1_data;

  always_ff @(posedge clk) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    s1_sof  <= in_sof;
    s1_eof  <= in_eof;
    s1_chip <= in_chip;
    s1_chan <= in_chan;
    s1_data <= in_data;
  end

  // Decision, exposed by name for the checker.
  logic [NSAMP-1:0] above_mask;
  logic             s1_pass;

  msf_run_judge #(.NSAMP(NSAMP), .SAMP_W(SAMP_W)) u_judge (
    .data      (s1_data),
    .thr       (thr_q),
    .min_run   (cfg_min_run),
    .filter_en (cfg_filter_en),
    .above     (above_mask),
    .pass      (s1_pass)
  );

  logic held_valid;
  logic held_eof;

  msf_frame_keeper #(.CHIP_W(CHIP_W), .CHAN_W(CHAN_W), .MS_W(MS_W)) u_keep (
    .clk        (clk),
    .rst_n      (rst_n),
    .d_valid    (s1_valid),
    .d_pass     (s1_pass),
    .d_sof      (s1_sof),
    .d_eof      (s1_eof),
    .d_chip     (s1_chip),
    .d_chan     (s1_chan),
    .d_data     (s1_data),
    .held_valid (held_valid),
    .held_eof   (held_eof),
    .out_valid  (out_valid),
    .out_sof    (out_sof),
    .out_eof    (out_eof),
    .out_chip   (out_chip),
    .out_chan   (out_chan),
    .out_data   (out_data)
  );

endmodule

// File: rtl/msample_thresh_filter_chk.sv
module msample_thresh_filter_chk #(
  parameter int NSAMP = 6,
  parameter int RUN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_filter_en,
  input logic [RUN_W-1:0] cfg_min_run,
  input logic             s1_valid,
  input logic             s1_pass,
  input logic             s1_eof,
  input logic [NSAMP-1:0] above_mask,
  input logic             held_valid,
  input logic             held_eof,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eof
);

  // Tracks whether an output frame has been opened and not yet closed.
  logic open_q;
  always_ff @(posedge clk) begin
    if (!rst_n)         open_q <= 1'b0;
    else if (out_valid) open_q <= !out_eof;
  end

  // R1: an output word only follows a decided or held input word.
  assert_out_from_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(s1_valid) || $past(held_valid)));

  // R4: a passing word under an active filter has at least N samples above.
  assert_pass_has_enough_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_pass && cfg_filter_en && (cfg_min_run != '0))
      |-> ($countones(above_mask) >= int'(cfg_min_run)));

  // R5: a dropped mid-frame word with nothing pending to flush emits nothing.
  assert_drop_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_pass && !s1_eof && !(held_valid && held_eof))
      |=> !out_valid);

  // R6: bypass settings let every word through.
  assert_bypass_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && (!cfg_filter_en || (cfg_min_run == '0))) |-> s1_pass);

  // R7: a run length beyond the sample count drops everything.
  assert_long_run_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && cfg_filter_en && (int'(cfg_min_run) > NSAMP)) |-> !s1_pass);

  // R9: start marker exactly on the words that open an output frame.
  assert_frame_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sof == !open_q));

endmodule

bind msample_thresh_filter msample_thresh_filter_chk #(
  .NSAMP (NSAMP),
  .RUN_W (RUN_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_filter_en (cfg_filter_en),
  .cfg_min_run   (cfg_min_run),
  .s1_valid      (s1_valid),
  .s1_pass       (s1_pass),
  .s1_eof        (s1_eof),
  .above_mask    (above_mask),
  .held_valid    (held_valid),
  .held_eof      (held_eof),
  .out_valid     (out_valid),
  .out_sof       (out_sof),
  .out_eof       (out_eof)
);

// File: tb/msample_thresh_filter_test.sv
module msample_thresh_filter_test;

  localparam int MS_W   = 96;
  localparam int CHIP_W = 5;
  localparam int CHAN_W = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_thr_we = 1'b0;
  logic [CHIP_W-1:0] cfg_thr_chip = '0;
  logic [CHAN_W-1:0] cfg_thr_chan = '0;
  logic [15:0]       cfg_thr_value = '0;
  logic [2:0]        cfg_min_run = 3'd1;
  logic              cfg_filter_en = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_sof = 1'b0;
  logic              in_eof = 1'b0;
  logic [CHIP_W-1:0] in_chip = '0;
  logic [CHAN_W-1:0] in_chan = '0;
  logic [MS_W-1:0]   in_data = '0;
  logic              out_valid;
  logic              out_sof;
  logic              out_eof;
  logic [CHIP_W-1:0] out_chip;
  logic [CHAN_W-1:0] out_chan;
  logic [MS_W-1:0]   out_data;

  msample_thresh_filter uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_thr_we(cfg_thr_we), .cfg_thr_chip(cfg_thr_chip),
    .cfg_thr_chan(cfg_thr_chan), .cfg_thr_value(cfg_thr_value),
    .cfg_min_run(cfg_min_run), .cfg_filter_en(cfg_filter_en),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_chip(in_chip), .in_chan(in_chan), .in_data(in_data),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .out_chip(out_chip), .out_chan(out_chan), .out_data(out_data)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Output monitor, sampled away from the active edge.
  logic [MS_W-1:0]   q_data[$];
  logic [CHIP_W-1:0] q_chip[$];
  logic [CHAN_W-1:0] q_chan[$];
  logic              q_sof[$];
  logic              q_eof[$];

  always @(negedge clk) begin
    if (out_valid) begin
      q_data.push_back(out_data);
      q_chip.push_back(out_chip);
      q_chan.push_back(out_chan);
      q_sof.push_back(out_sof);
      q_eof.push_back(out_eof);
    end
  end

  task automatic clear_q();
    q_data.delete(); q_chip.delete(); q_chan.delete();
    q_sof.delete();  q_eof.delete();
  endtask

  task automatic chk(input bit ok, input string what,
                     input logic [MS_W-1:0] act, input logic [MS_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic write_thr(input int chip, input int chan, input logic [15:0] v);
    cfg_thr_we    = 1'b1;
    cfg_thr_chip  = CHIP_W'(chip);
    cfg_thr_chan  = CHAN_W'(chan);
    cfg_thr_value = v;
    @(negedge clk);
    cfg_thr_we = 1'b0;
  endtask

  task automatic send(input bit sof, input bit eof, input int chip, input int chan,
                      input logic [MS_W-1:0] d);
    in_valid = 1'b1;
    in_sof   = sof;
    in_eof   = eof;
    in_chip  = CHIP_W'(chip);
    in_chan  = CHAN_W'(chan);
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [MS_W-1:0] rep(input logic [15:0] v);
    return {6{v}};
  endfunction

  // Stimulus/expectation table. Data is written sample 5 first, sample 0 last.
  typedef struct packed {
    logic [15:0]     thr;
    logic [MS_W-1:0] data;
    logic [2:0]      n;
    logic            en;
    logic            exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'd100,    {6{16'd200}}, 3'd6, 1'b1, 1'b1},                          // R4 full run
    '{16'd100,    {16'd50,16'd200,16'd200,16'd50,16'd200,16'd200}, 3'd3, 1'b1, 1'b0}, // R4 split runs
    '{16'd100,    {16'd50,16'd200,16'd200,16'd50,16'd200,16'd200}, 3'd2, 1'b1, 1'b1}, // R4 run of two
    '{16'd100,    {6{16'd100}}, 3'd1, 1'b1, 1'b0},                          // R3 equal
    '{16'd100,    {16'd101,16'd0,16'd0,16'd0,16'd0,16'd0}, 3'd1, 1'b1, 1'b1}, // R3 one above, top slot
    '{16'd100,    {6{16'd200}}, 3'd7, 1'b1, 1'b0},                          // R7
    '{16'd100,    {6{16'd0}},   3'd0, 1'b1, 1'b1},                          // R6 N=0
    '{16'd100,    {6{16'd0}},   3'd3, 1'b0, 1'b1},                          // R6 disabled
    '{16'hFFFF,   {6{16'hFFFF}}, 3'd1, 1'b1, 1'b0},                         // R3 max equal
    '{16'd0,      {16'd1,16'd0,16'd1,16'd1,16'd1,16'd0}, 3'd3, 1'b1, 1'b1}, // R4 middle run
    '{16'h8000,   {16'h0,16'h8001,16'h8001,16'h8001,16'h8001,16'h0}, 3'd4, 1'b1, 1'b1}, // R3 unsigned
    '{16'h7FFF,   {6{16'h8000}}, 3'd6, 1'b1, 1'b1},                         // R3 unsigned, not signed
    '{16'd100,    {16'd200,16'd200,16'd50,16'd200,16'd200,16'd200}, 3'd4, 1'b1, 1'b0}  // R4 five above, no run of four
  };

  // Watchdog.
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [MS_W-1:0] e_data [4];
    logic [CHAN_W-1:0] e_chan [4];
    logic e_sof [4];
    logic e_eof [4];

    // ---------------- Reset (R1) ----------------
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid during reset", MS_W'(out_valid), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", MS_W'(out_valid), '0);
    chk(q_data.size() == 0, "R1 no words after reset", MS_W'(q_data.size()), '0);

    // ---------------- Vector table (R3 R4 R6 R7 R5 R8) ----------------
    for (int i = 0; i < NV; i++) begin
      int chip;
      int chan;
      chip = i;
      chan = 127 - i * 7;
      cfg_min_run   = VECS[i].n;
      cfg_filter_en = VECS[i].en;
      clear_q();
      write_thr(chip, chan, VECS[i].thr);
      send(1'b1, 1'b1, chip, chan, VECS[i].data);
      settle();
      chk(q_data.size() == int'(VECS[i].exp),
          $sformatf("R4/R5 vector %0d survivor count", i),
          MS_W'(q_data.size()), MS_W'(VECS[i].exp));
      if (VECS[i].exp && q_data.size() == 1) begin
        chk(q_data[0] == VECS[i].data && q_chip[0] == CHIP_W'(chip) &&
            q_chan[0] == CHAN_W'(chan),
            $sformatf("R8 vector %0d data unchanged", i), q_data[0], VECS[i].data);
        chk(q_sof[0] && q_eof[0], $sformatf("R9 vector %0d single-word markers", i),
            MS_W'({q_sof[0], q_eof[0]}), MS_W'(2'b11));
      end
    end

    // ---------------- Per-channel lookup (R2) ----------------
    cfg_filter_en = 1'b1;
    cfg_min_run   = 3'd1;
    write_thr(3, 5, 16'd1000);
    write_thr(3, 6, 16'd10);
    write_thr(4, 5, 16'd100);
    write_thr(0, 0, 16'd300);
    write_thr(19, 127, 16'd300);
    clear_q();
    send(1'b1, 1'b1, 3, 5, rep(16'd500));
    send(1'b1, 1'b1, 3, 6, rep(16'd500));
    send(1'b1, 1'b1, 4, 5, rep(16'd500));
    send(1'b1, 1'b1, 0, 0, rep(16'd500));
    send(1'b1, 1'b1, 19, 127, rep(16'd500));
    settle();
    chk(q_data.size() == 4, "R2 survivors of per-channel lookup",
        MS_W'(q_data.size()), MS_W'(4));
    if (q_data.size() == 4) begin
      chk(q_chip[0] == 5'd3 && q_chan[0] == 7'd6, "R2 first survivor chip3 chan6",
          MS_W'({q_chip[0], q_chan[0]}), MS_W'({5'd3, 7'd6}));
      chk(q_chip[1] == 5'd4 && q_chan[1] == 7'd5, "R2 chip4 chan5 uses own entry",
          MS_W'({q_chip[1], q_chan[1]}), MS_W'({5'd4, 7'd5}));
      chk(q_chip[2] == 5'd0 && q_chan[2] == 7'd0, "R2 lowest entry",
          MS_W'({q_chip[2], q_chan[2]}), MS_W'({5'd0, 7'd0}));
      chk(q_chip[3] == 5'd19 && q_chan[3] == 7'd127, "R2 highest entry",
          MS_W'({q_chip[3], q_chan[3]}), MS_W'({5'd19, 7'd127}));
    end

    // ---------------- Framing and order (R9 R8 R5) ----------------
    cfg_min_run = 3'd2;
    for (int c = 0; c < 10; c++) write_thr(1, c, 16'd100);
    clear_q();
    // Frame A: markers on dropped words, two interior survivors.
    send(1'b1, 1'b0, 1, 0, rep(16'd10));
    send(1'b0, 1'b0, 1, 1, rep(16'h0201));
    send(1'b0, 1'b0, 1, 2, rep(16'h0202));
    send(1'b0, 1'b1, 1, 3, rep(16'd10));
    // Frame B: nothing survives.
    send(1'b1, 1'b0, 1, 4, rep(16'd10));
    send(1'b0, 1'b0, 1, 5, rep(16'd10));
    send(1'b0, 1'b1, 1, 6, rep(16'd10));
    // Frame C: both marker words survive, middle dropped.
    send(1'b1, 1'b0, 1, 7, rep(16'h0207));
    send(1'b0, 1'b0, 1, 8, rep(16'd10));
    send(1'b0, 1'b1, 1, 9, rep(16'h0209));
    repeat (3) @(negedge clk);
    e_data = '{rep(16'h0201), rep(16'h0202), rep(16'h0207), rep(16'h0209)};
    e_chan = '{7'd1, 7'd2, 7'd7, 7'd9};
    e_sof  = '{1'b1, 1'b0, 1'b1, 1'b0};
    e_eof  = '{1'b0, 1'b1, 1'b0, 1'b1};
    chk(q_data.size() == 4, "R9 survivors released within three cycles",
        MS_W'(q_data.size()), MS_W'(4));
    if (q_data.size() == 4) begin
      for (int k = 0; k < 4; k++) begin
        chk(q_data[k] == e_data[k] && q_chan[k] == e_chan[k],
            $sformatf("R8 order word %0d", k), q_data[k], e_data[k]);
        chk(q_sof[k] == e_sof[k] && q_eof[k] == e_eof[k],
            $sformatf("R9 markers word %0d", k),
            MS_W'({q_sof[k], q_eof[k]}), MS_W'({e_sof[k], e_eof[k]}));
      end
    end

    // ---------------- Write takes effect next cycle (R10) ----------------
    cfg_min_run = 3'd1;
    clear_q();
    write_thr(2, 9, 16'd50);
    send(1'b1, 1'b1, 2, 9, rep(16'd60));
    write_thr(2, 9, 16'd70);
    send(1'b1, 1'b1, 2, 9, rep(16'd60));
    settle();
    chk(q_data.size() == 1, "R10 write governs the next-cycle word",
        MS_W'(q_data.size()), MS_W'(1));

    // ---------------- Disabled filter keeps a whole frame (R6) ----------------
    for (int c = 0; c < 3; c++) write_thr(5, c, 16'hFFFF);
    cfg_filter_en = 1'b0;
    cfg_min_run   = 3'd6;
    clear_q();
    send(1'b1, 1'b0, 5, 0, rep(16'd0));
    send(1'b0, 1'b0, 5, 1, rep(16'd1));
    send(1'b0, 1'b1, 5, 2, rep(16'd2));
    settle();
    chk(q_data.size() == 3, "R6 disabled filter keeps all words",
        MS_W'(q_data.size()), MS_W'(3));
    if (q_data.size() == 3) begin
      chk(q_data[1] == rep(16'd1) && q_sof[0] && !q_eof[0] && !q_sof[1] && q_eof[2],
          "R6 bypassed frame unchanged", q_data[1], rep(16'd1));
    end
    // Re-enable: the same frame is now dropped entirely.
    cfg_filter_en = 1'b1;
    clear_q();
    send(1'b1, 1'b0, 5, 0, rep(16'd0));
    send(1'b0, 1'b1, 5, 1, rep(16'd1));
    settle();
    chk(q_data.size() == 0, "R5 enabled filter drops frame with no survivors",
        MS_W'(q_data.size()), '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule